// File: doc/BRIEF.md
# ROM-Driven Reconfiguration Sequencer

This block replays a stored configuration profile from a synchronous ROM into a downstream write-request port. The ROM holds two profiles at fixed base addresses, a full-rate one and a reduced-rate one. A one-cycle `start` pulse picks one of them with `sel_down`. The sequencer then reads word by word from that base and forwards each configuration word over a valid/ready handshake. It finds where a record begins and ends from the word contents, not from a stored length.

Two mode inputs, sampled with `start`, select the record format. With `mark_en` high, a record must open with the `START_MARK` word and closes at the `END_MARK` word. With `mark_en` low, there is no opening word and the record closes at a word of all ones. With `dual_rec` high, a profile is made of two records back to back, for example a PLL record followed by a lane record. The walk then continues past the first closing word and reports completion only at the second one. Marker and terminator words are never forwarded.

The controller is a six-state machine:
- IDLE waits for `start` and loads the base address.
- ISSUE presents the address, or moves to FAIL once `ROM_DEPTH` words have been consumed.
- EVAL classifies the returned word:
  - An expected opening marker advances to ISSUE, and a missing one moves to FAIL.
  - A closing word returns to ISSUE for the second record, or moves to DONE.
  - A data word moves to SEND.
- SEND holds the word until `out_ready` and then returns to ISSUE.
- DONE and FAIL hold their flag and leave for ISSUE on the next `start`.

Top module: `rom_reconfig_seq`

## Requirements
- R1: On an accepted `start`, the first ROM address presented is `BASE_MAX` (default 0) when `sel_down` is 0 and `BASE_DOWN` (default 64) when `sel_down` is 1.
- R2: With `mark_en`=1, the word at the base must equal `START_MARK` (default 0x3E). The following words are forwarded in ROM order up to the first `END_MARK` word (default 0x3F), which is not forwarded, and `done` then rises.
- R3: With `dual_rec`=1, after the first closing word the walk continues at the next address with a second record in the same format. When `mark_en`=1, that second record also needs its own opening marker. `done` rises only at the second closing word.
- R4: With `mark_en`=0, no opening marker is checked and the record ends at the first all-ones word. No ROM address beyond that terminator is presented during the walk.
- R5: `out_valid` stays high with `out_data` and `rom_addr` stable until `out_ready` is high. The address advances only on acceptance, so every word is forwarded exactly once.
- R6: A missing opening marker, at the base or at the start of the second record, raises `err`, sets `done` low, and forwards no data from that record onward.
- R7: If no closing word is met after `ROM_DEPTH` words have been read, the walk stops with `err` high. The address wraps modulo the depth, so the forwarded count is at most `ROM_DEPTH`.
- R8: A `start` pulse while `busy` is high has no effect on the profile, the format or the forwarded data.
- R9: After reset, `busy`, `done`, `err` and `out_valid` are low. `done` or `err` stays high until the next `start`, and both are low one cycle after that `start`.
- R10: `busy` is high from the cycle after an accepted `start` until the cycle in which `done` or `err` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| sel_down | input | 1 | 0 selects the full-rate profile, 1 the reduced-rate profile |
| mark_en | input | 1 | 1: records carry opening and closing markers; 0: all-ones terminator only |
| dual_rec | input | 1 | 1: a profile holds two consecutive records |
| rom_addr | output | $clog2(ROM_DEPTH) | ROM read address |
| rom_rdata | input | DATA_W | ROM read data, one cycle after the address |
| out_valid | output | 1 | Configuration word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | DATA_W | Configuration word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk ended at its closing word (sticky) |
| err | output | 1 | Walk aborted (sticky) |

## Verification
Most internal faults in this block show up at the ports during the very walk in which they occur. A wrong opening-marker flag or a wrong record counter either forwards a marker word or ends the walk one record early. Either way the captured word stream differs from the expected list, and `done` or `err` takes the wrong value by the end of that walk. An address that advances without a handshake appears as a dropped or repeated word within a few cycles of the stall, and the random backpressure is there to expose it. A wrong base or a read past the terminator shows on `rom_addr` at the first ISSUE cycle or in the last cycles of the walk.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_EVAL,
        ST_SEND,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        WK_DATA,
        WK_START,
        WK_END
    } word_kind_t;

endpackage

// File: rtl/rs_classify.sv
module rs_classify
    import rs_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter logic [DATA_W-1:0] START_MARK = 'h3E,
    parameter logic [DATA_W-1:0] END_MARK   = 'h3F
) (
    input  logic [DATA_W-1:0] word,
    input  logic              mark_en,
    output word_kind_t        kind
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    always_comb begin
        kind = WK_DATA;
        if (mark_en) begin
            if (word == END_MARK)        kind = WK_END;
            else if (word == START_MARK) kind = WK_START;
        end else if (word == ALL_ONES) begin
            kind = WK_END;
        end
    end

endmodule

// File: rtl/rs_addr_gen.sv
module rs_addr_gen #(
    parameter int ROM_DEPTH = 128,
    parameter int BASE_MAX  = 0,
    parameter int BASE_DOWN = 64,
    parameter int ADDR_W    = 7,
    parameter int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              sel_down,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic              limit_hit
);

    localparam logic [ADDR_W-1:0] BASE_M = ADDR_W'(BASE_MAX);
    localparam logic [ADDR_W-1:0] BASE_D = ADDR_W'(BASE_DOWN);
    localparam logic [CNT_W-1:0]  LIMIT  = CNT_W'(ROM_DEPTH);

    logic [CNT_W-1:0] rd_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            rd_cnt <= '0;
        end else if (load) begin
            addr   <= sel_down ? BASE_D : BASE_M;
            rd_cnt <= '0;
        end else if (adv) begin
            addr   <= addr + 1'b1;
            rd_cnt <= rd_cnt + 1'b1;
        end
    end

    assign limit_hit = (rd_cnt == LIMIT);

    // R1: the selected base appears right after a load
    p_base_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr == ($past(sel_down) ? BASE_D : BASE_M));

    // R7: the word counter never passes the depth limit
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= LIMIT);

endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
    import rs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       mark_en,
    input  logic       dual_rec,
    input  word_kind_t kind,
    input  logic       limit_hit,
    input  logic       out_ready,
    output logic       load,
    output logic       adv,
    output logic       lat_en,
    output logic       mark_q,
    output logic       out_valid,
    output logic       busy,
    output logic       done,
    output logic       err
);

    seq_state_t state, nxt;
    logic       dual_q;
    logic       need_start;
    logic       second;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            mark_q     <= 1'b0;
            dual_q     <= 1'b0;
            need_start <= 1'b0;
            second     <= 1'b0;
        end else begin
            state <= nxt;
            if (load) begin
                mark_q     <= mark_en;
                dual_q     <= dual_rec;
                need_start <= mark_en;
                second     <= 1'b0;
            end else if (state == ST_EVAL && adv) begin
                if (need_start) begin
                    need_start <= 1'b0;
                end else begin
                    second     <= 1'b1;
                    need_start <= mark_q;
                end
            end
        end
    end

    always_comb begin
        nxt    = state;
        load   = 1'b0;
        adv    = 1'b0;
        lat_en = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    load = 1'b1;
                    nxt  = ST_ISSUE;
                end
            end
            ST_ISSUE: nxt = limit_hit ? ST_FAIL : ST_EVAL;
            ST_EVAL: begin
                if (need_start) begin
                    if (kind == WK_START) begin
                        adv = 1'b1;
                        nxt = ST_ISSUE;
                    end else begin
                        nxt = ST_FAIL;
                    end
                end else if (kind == WK_END) begin
                    if (dual_q && !second) begin
                        adv = 1'b1;
                        nxt = ST_ISSUE;
                    end else begin
                        nxt = ST_DONE;
                    end
                end else begin
                    lat_en = 1'b1;
                    nxt    = ST_SEND;
                end
            end
            ST_SEND: begin
                if (out_ready) begin
                    adv = 1'b1;
                    nxt = ST_ISSUE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        out_valid = (state == ST_SEND);
        busy      = (state == ST_ISSUE) || (state == ST_EVAL) || (state == ST_SEND);
        done      = (state == ST_DONE);
        err       = (state == ST_FAIL);
    end

    // R9: completion flags hold until a new start
    p_sticky_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);
    p_sticky_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err && !start |=> err);

    // R8: the latched format is untouched during a walk
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(mark_q) && $stable(dual_q));

    // R6: a wrong word where an opening marker belongs aborts the walk
    p_missing_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVAL) && need_start && (kind != WK_START) |=> err);

    // R3: the first closing word of a two-record profile keeps the walk going
    p_dual_continue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVAL) && !need_start && (kind == WK_END) && dual_q && !second
        |=> busy && !done);

endmodule

// File: rtl/rom_reconfig_seq.sv
module rom_reconfig_seq
    import rs_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter int                ROM_DEPTH  = 128,
    parameter int                BASE_MAX   = 0,
    parameter int                BASE_DOWN  = 64,
    parameter logic [DATA_W-1:0] START_MARK = 'h3E,
    parameter logic [DATA_W-1:0] END_MARK   = 'h3F,
    localparam int               ADDR_W     = $clog2(ROM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sel_down,
    input  logic              mark_en,
    input  logic              dual_rec,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              busy,
    output logic              done,
    output logic              err
);

    localparam int CNT_W = $clog2(ROM_DEPTH + 1);

    word_kind_t        kind;
    logic              load, adv, lat_en, mark_q, limit_hit;
    logic [DATA_W-1:0] data_q;

    rs_classify #(
        .DATA_W    (DATA_W),
        .START_MARK(START_MARK),
        .END_MARK  (END_MARK)
    ) u_classify (
        .word   (rom_rdata),
        .mark_en(mark_q),
        .kind   (kind)
    );

    rs_addr_gen #(
        .ROM_DEPTH(ROM_DEPTH),
        .BASE_MAX (BASE_MAX),
        .BASE_DOWN(BASE_DOWN),
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .sel_down (sel_down),
        .adv      (adv),
        .addr     (rom_addr),
        .limit_hit(limit_hit)
    );

    rs_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mark_en  (mark_en),
        .dual_rec (dual_rec),
        .kind     (kind),
        .limit_hit(limit_hit),
        .out_ready(out_ready),
        .load     (load),
        .adv      (adv),
        .lat_en   (lat_en),
        .mark_q   (mark_q),
        .out_valid(out_valid),
        .busy     (busy),
        .done     (done),
        .err      (err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (lat_en) data_q <= rom_rdata;
    end

    assign out_data = data_q;

    // R5: a stalled word and its address hold until accepted
    p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(rom_addr));

endmodule

// File: tb/test_rom_reconfig_seq.sv
module test_rom_reconfig_seq;

    localparam int          DW    = 32;
    localparam int          DEPTH = 128;
    localparam int          BMAX  = 0;
    localparam int          BDOWN = 64;
    localparam logic [31:0] SMK   = 32'h3E;
    localparam logic [31:0] EMK   = 32'h3F;
    localparam logic [31:0] ONES  = 32'hFFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, sel_down = 1'b0, mark_en = 1'b0, dual_rec = 1'b0;
    logic [6:0]    rom_addr;
    logic [DW-1:0] rom_rdata;
    logic          out_valid, out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic          busy, done, err;

    logic [DW-1:0] rom [DEPTH];
    logic [DW-1:0] exp_data [256];
    logic [DW-1:0] got_data [256];
    int exp_n, got_n, max_addr, first_addr;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) rom_rdata <= rom[rom_addr];

    rom_reconfig_seq #(
        .DATA_W(DW), .ROM_DEPTH(DEPTH), .BASE_MAX(BMAX), .BASE_DOWN(BDOWN),
        .START_MARK(SMK), .END_MARK(EMK)
    ) i_rom_reconfig_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .sel_down(sel_down),
        .mark_en(mark_en), .dual_rec(dual_rec), .rom_addr(rom_addr),
        .rom_rdata(rom_rdata), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .busy(busy), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] rnd_word();
        logic [31:0] w;
        do w = $urandom; while (w == SMK || w == EMK || w == ONES);
        return w;
    endfunction

    task automatic clear_rom();
        for (int i = 0; i < DEPTH; i++) rom[i] = '0;
        exp_n = 0;
    endtask

    // One record at pos; returns the address of its closing word in last
    task automatic add_record(inout int pos, input int n, input bit mark, input bit to_exp, output int last);
        if (mark) begin rom[pos] = SMK; pos++; end
        for (int i = 0; i < n; i++) begin
            logic [31:0] w = rnd_word();
            rom[pos] = w;
            if (to_exp) begin exp_data[exp_n] = w; exp_n++; end
            pos++;
        end
        rom[pos] = mark ? EMK : ONES;
        last = pos;
        pos++;
    endtask

    task automatic run_walk(input bit sel, input bit mark, input bit dual, input int rdy_pct, input bit poke);
        int cyc = 0;
        got_n = 0; max_addr = 0; first_addr = -1;
        @(negedge clk);
        start = 1'b1; sel_down = sel; mark_en = mark; dual_rec = dual;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done && !err, "R9 flags clear after start", {busy, done, err}, 3'b100);
        while (!(done || err) && cyc < 20000) begin
            out_ready = ($urandom_range(99) < rdy_pct);
            if (busy) begin
                if (first_addr < 0) first_addr = int'(rom_addr);
                if (int'(rom_addr) > max_addr) max_addr = int'(rom_addr);
            end
            if (out_valid && out_ready && got_n < 256) begin
                got_data[got_n] = out_data;
                got_n++;
            end
            if (poke && cyc == 6) begin
                start = 1'b1; sel_down = !sel; mark_en = !mark; dual_rec = !dual;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        out_ready = 1'b0;
    endtask

    task automatic compare(input string req, input bit exp_err, input int base, input int last);
        check(err == exp_err && done == !exp_err, {req, " end flags"}, {done, err}, {!exp_err, exp_err});
        check(first_addr == base, "R1 first address", first_addr, base);
        check(got_n == exp_n, {req, " word count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            check(got_data[i] == exp_data[i], {req, " word"}, got_data[i], exp_data[i]);
        if (last >= 0) check(max_addr == last, "R4 highest address read", max_addr, last);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int pos, last, dummy;
        void'($urandom(32'd20240601));
        clear_rom();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check({busy, done, err, out_valid} == 4'b0, "R9 reset outputs", {busy, done, err, out_valid}, 0);

        // R2 marked record, full-rate profile, no backpressure; decoy in other profile
        clear_rom();
        pos = BMAX;  add_record(pos, 12, 1, 1, last);
        pos = BDOWN; add_record(pos, 5, 1, 0, dummy);
        run_walk(0, 1, 0, 100, 0);
        compare("R2", 0, BMAX, -1);
        // R9 done stays up without start
        repeat (5) @(negedge clk);
        check(done && !busy, "R9 done sticky", done, 1);

        // R2/R5 reduced-rate profile with heavy backpressure
        clear_rom();
        pos = BMAX;  add_record(pos, 7, 1, 0, dummy);
        pos = BDOWN; add_record(pos, 15, 1, 1, last);
        run_walk(1, 1, 0, 30, 0);
        compare("R5", 0, BDOWN, -1);

        // R3 two marked records
        clear_rom();
        pos = BDOWN; add_record(pos, 6, 1, 1, dummy); add_record(pos, 9, 1, 1, last);
        run_walk(1, 1, 1, 60, 0);
        compare("R3", 0, BDOWN, last);

        // R4 terminator-only, link-parameter style: 1,1,1 then all ones; zero padding after
        clear_rom();
        rom[0] = 1; rom[1] = 1; rom[2] = 1; rom[3] = ONES;
        rom[64] = 0; rom[65] = 0; rom[66] = 1; rom[67] = ONES;
        exp_data[0] = 1; exp_data[1] = 1; exp_data[2] = 1; exp_n = 3;
        run_walk(0, 0, 0, 100, 0);
        compare("R4", 0, BMAX, 3);
        exp_data[0] = 0; exp_data[1] = 0; exp_data[2] = 1; exp_n = 3;
        run_walk(1, 0, 0, 50, 0);
        compare("R4", 0, BDOWN, 67);

        // R6 missing opening marker at base
        clear_rom();
        rom[BMAX] = rnd_word(); rom[BMAX + 1] = rnd_word(); rom[BMAX + 2] = EMK;
        run_walk(0, 1, 0, 100, 0);
        compare("R6", 1, BMAX, -1);

        // R6 missing opening marker on the second record
        clear_rom();
        pos = BDOWN; add_record(pos, 4, 1, 1, dummy);
        rom[pos] = rnd_word(); rom[pos + 1] = EMK;
        run_walk(1, 1, 1, 100, 0);
        compare("R6", 1, BDOWN, -1);

        // R2 empty record
        clear_rom();
        rom[BDOWN] = SMK; rom[BDOWN + 1] = EMK;
        run_walk(1, 1, 0, 100, 0);
        compare("R2", 0, BDOWN, BDOWN + 1);

        // R7 no terminator anywhere: whole ROM forwarded from the base, with wrap
        clear_rom();
        for (int i = 0; i < DEPTH; i++) rom[i] = rnd_word();
        for (int i = 0; i < DEPTH; i++) exp_data[i] = rom[(BDOWN + i) % DEPTH];
        exp_n = DEPTH;
        run_walk(1, 0, 0, 100, 0);
        compare("R7", 1, BDOWN, -1);

        // R8 start pulse while busy with flipped selection and format
        clear_rom();
        pos = BMAX;  add_record(pos, 10, 1, 1, last);
        pos = BDOWN; add_record(pos, 3, 0, 0, dummy);
        run_walk(0, 1, 0, 70, 1);
        compare("R8", 0, BMAX, -1);

        // R10 busy low once finished
        check(!busy, "R10 busy low after walk", busy, 0);

        // Random mixes of profile, format and backpressure
        for (int it = 0; it < 8; it++) begin
            bit s = $urandom_range(1);
            bit m = $urandom_range(1);
            bit d = $urandom_range(1);
            int base = s ? BDOWN : BMAX;
            int other = s ? BMAX : BDOWN;
            clear_rom();
            pos = other; add_record(pos, 4, m, 0, dummy);
            pos = base;  add_record(pos, $urandom_range(20), m, 1, last);
            if (d) add_record(pos, $urandom_range(20), m, 1, last);
            run_walk(s, m, d, 20 + $urandom_range(80), 0);
            compare(d ? "R3 random" : "R2 random", 0, base, last);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule